// File: doc/BRIEF.md
# Receive Frame Statistics Classifier

This block sits at the tail of an Ethernet receive path. When a frame finishes, it decides which of three statistics counters the frame should advance: the good-frame counter, the good-broadcast counter and the good-multicast counter. The inputs are an end-of-frame strobe and a snapshot of that frame: destination address, byte length, address-acceptance results and receive error flags. The outputs are single-cycle increment strobes that external counters consume.

A frame is good when the address filter accepted it (a direct match or promiscuous acceptance), its length is inside the legal window and it carries no CRC, alignment or code error. A run-time maximum-length input sets the upper bound of that window. The minimum bound is a parameter. Broadcast and multicast are subclasses of good frames, and they never overlap. The overrun indication is accepted at the port but has no effect on any decision.

Top module: `rx_stat_classifier`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises with no frame presented, all three strobes are 0.
- R2: Strobes change only in the clock cycle after a cycle in which `frameEnd` was 1. A cycle with `frameEnd` at 0 is followed by all strobes at 0, so each frame yields pulses exactly one cycle wide.
- R3: `incGood` needs `addrHit` or `promiscHit` at 1. A frame with both at 0 never counts.
- R4: `incGood` needs `frameLen` to be at least MIN_LEN (default 64) and at most `maxLen`, with both bounds inclusive. If `maxLen` is below MIN_LEN, no frame is good.
- R5: Any of `crcErr`, `alignErr` or `codeErr` at 1 blocks `incGood` and therefore blocks all strobes.
- R6: `incBcast` pulses only for a good frame whose `destAddr` is all ones (48'hFFFF_FFFF_FFFF).
- R7: `incMcast` pulses for a good frame whose group bit is set and whose address is not all ones. The group bit is `destAddr[40]`, the least significant bit of the first transmitted byte, which sits at `destAddr[47:40]`.
- R8: Every broadcast or multicast pulse comes together with an `incGood` pulse in the same cycle. `incBcast` and `incMcast` are never 1 together.
- R9: `overrun` has no effect. Frames that differ only in `overrun` yield identical strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameEnd | input | 1 | One-cycle end-of-frame strobe; other frame inputs are valid with it |
| destAddr | input | 48 | Destination address, first byte in bits 47:40 |
| frameLen | input | LEN_W | Frame length in bytes |
| maxLen | input | LEN_W | Largest accepted length, inclusive |
| addrHit | input | 1 | Address filter matched a unicast, broadcast or multicast entry |
| promiscHit | input | 1 | Frame accepted by promiscuous mode |
| crcErr | input | 1 | Frame check sequence error |
| alignErr | input | 1 | Alignment error |
| codeErr | input | 1 | Line code error |
| overrun | input | 1 | Receive overrun indication (ignored) |
| incGood | output | 1 | Good-frame counter increment |
| incBcast | output | 1 | Good-broadcast counter increment |
| incMcast | output | 1 | Good-multicast counter increment |

## Verification
The bench builds the block with its default parameters: LEN_W of 14 and MIN_LEN of 64. With these, lengths up to 16383 can be presented, and both length boundaries are approached from either side. Because `maxLen` is an input, the bench moves the upper bound at run time through a standard 1518, a narrow 100 and an illegal 63. This makes the inclusive upper edge and the empty window reachable without rebuilding. Address patterns cover unicast, all ones, group addresses differing from all ones in a single bit, and the overrun pairing.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
  localparam int MAC_W = 48;
  localparam int GROUP_BIT = MAC_W - 8;

  typedef struct packed {
    logic lenOk;
    logic allOnes;
    logic groupAddr;
  } frameInfo_t;

  typedef struct packed {
    logic good;
    logic bcast;
    logic mcast;
  } qualStrobes_t;
endpackage

// File: rtl/rx_stat_dp.sv
module rx_stat_dp
  import rx_stat_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64
) (
  input  logic [MAC_W-1:0] destAddr,
  input  logic [LEN_W-1:0] frameLen,
  input  logic [LEN_W-1:0] maxLen,
  output frameInfo_t       info
);
  localparam logic [LEN_W-1:0] MinLenV = LEN_W'(MIN_LEN);

  logic aboveMin, belowMax;

  always_comb begin
    aboveMin       = frameLen >= MinLenV;
    belowMax       = frameLen <= maxLen;
    info.lenOk     = aboveMin && belowMax;
    info.allOnes   = &destAddr;
    info.groupAddr = destAddr[GROUP_BIT];
  end
endmodule

// File: rtl/rx_stat_ctrl.sv
module rx_stat_ctrl
  import rx_stat_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameEnd,
  input  logic         addrHit,
  input  logic         promiscHit,
  input  logic         crcErr,
  input  logic         alignErr,
  input  logic         codeErr,
  input  frameInfo_t   info,
  output qualStrobes_t strobes
);
  logic accepted, clean, goodNow;
  qualStrobes_t nextStrobes;

  always_comb begin
    accepted          = addrHit || promiscHit;
    clean             = !(crcErr || alignErr || codeErr);
    goodNow           = frameEnd && accepted && clean && info.lenOk;
    nextStrobes.good  = goodNow;
    nextStrobes.bcast = goodNow && info.allOnes;
    nextStrobes.mcast = goodNow && info.groupAddr && !info.allOnes;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobes <= '0;
    else       strobes <= nextStrobes;
  end

  // R2: no pulse without a frame end one cycle earlier
  assert_pulse_after_end_R2: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> (strobes == '0));

  assert_need_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !addrHit && !promiscHit) |=> !strobes.good);

  assert_len_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !info.lenOk) |=> !strobes.good);

  assert_err_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && (crcErr || alignErr || codeErr)) |=> (strobes == '0));

  assert_bcast_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !info.allOnes) |=> !strobes.bcast);

  assert_mcast_addr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !info.groupAddr) |=> !strobes.mcast);

  assert_sub_implies_good_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.bcast || strobes.mcast) |-> strobes.good);

  assert_class_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.bcast && strobes.mcast));
endmodule

// File: rtl/rx_stat_classifier.sv
module rx_stat_classifier
  import rx_stat_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameEnd,
  input  logic [47:0]      destAddr,
  input  logic [LEN_W-1:0] frameLen,
  input  logic [LEN_W-1:0] maxLen,
  input  logic             addrHit,
  input  logic             promiscHit,
  input  logic             crcErr,
  input  logic             alignErr,
  input  logic             codeErr,
  input  logic             overrun,
  output logic             incGood,
  output logic             incBcast,
  output logic             incMcast
);
  frameInfo_t   info;
  qualStrobes_t strobes;
  logic         unusedOverrun;

  // R9: overrun is deliberately not consumed by any decision
  assign unusedOverrun = overrun;

  rx_stat_dp #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_dp (
    .destAddr (destAddr),
    .frameLen (frameLen),
    .maxLen   (maxLen),
    .info     (info)
  );

  rx_stat_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameEnd   (frameEnd),
    .addrHit    (addrHit),
    .promiscHit (promiscHit),
    .crcErr     (crcErr),
    .alignErr   (alignErr),
    .codeErr    (codeErr),
    .info       (info),
    .strobes    (strobes)
  );

  assign incGood  = strobes.good;
  assign incBcast = strobes.bcast;
  assign incMcast = strobes.mcast;
endmodule

// File: tb/rx_stat_classifier_tb.sv
module rx_stat_classifier_tb;
  localparam int LEN_W = 14;
  localparam int MIN_LEN = 64;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] UCAST = 48'h0022_3344_5566;
  localparam logic [47:0] MCAST = 48'h0100_5E00_0001;
  localparam logic [47:0] NEARB = 48'hFFFF_FFFF_FFFE;

  logic clk = 0, rstN = 0;
  logic frameEnd = 0, addrHit = 0, promiscHit = 0;
  logic crcErr = 0, alignErr = 0, codeErr = 0, overrun = 0;
  logic [47:0] destAddr = '0;
  logic [LEN_W-1:0] frameLen = '0, maxLen = 14'd1518;
  logic incGood, incBcast, incMcast;

  int vectors = 0, fails = 0;
  logic [2:0] expQ[$];
  string tagQ[$];
  bit monitorOn = 0;

  always #10 clk = ~clk;

  rx_stat_classifier #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_dut (
    .clk(clk), .rstN(rstN), .frameEnd(frameEnd), .destAddr(destAddr),
    .frameLen(frameLen), .maxLen(maxLen), .addrHit(addrHit),
    .promiscHit(promiscHit), .crcErr(crcErr), .alignErr(alignErr),
    .codeErr(codeErr), .overrun(overrun), .incGood(incGood),
    .incBcast(incBcast), .incMcast(incMcast));

  function automatic logic [2:0] model(logic fe, logic [47:0] da, logic [LEN_W-1:0] len,
                                       logic [LEN_W-1:0] mx, logic hit, logic prom,
                                       logic ce, logic ae, logic ke);
    logic g, b, m;
    g = fe && (hit || prom) && (int'(len) >= MIN_LEN) && (len <= mx) && !(ce || ae || ke);
    b = g && (da == BCAST);
    m = g && da[40] && (da != BCAST);
    return {g, b, m};
  endfunction

  task automatic present(input logic fe, input logic [47:0] da, input int len,
                         input logic hit, input logic prom, input logic ce,
                         input logic ae, input logic ke, input logic ov, input string tag);
    @(negedge clk);
    frameEnd = fe; destAddr = da; frameLen = LEN_W'(len); addrHit = hit;
    promiscHit = prom; crcErr = ce; alignErr = ae; codeErr = ke; overrun = ov;
    expQ.push_back(model(fe, da, LEN_W'(len), maxLen, hit, prom, ce, ae, ke));
    tagQ.push_back(tag);
  endtask

  task automatic idle(input string tag);
    present(0, BCAST, 100, 1, 1, 0, 0, 0, 0, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (monitorOn && expQ.size() > 0) begin
        logic [2:0] e, got;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        got = {incGood, incBcast, incMcast};
        vectors++;
        if (got !== e) begin
          fails++;
          $display("FAIL %s: got good/bcast/mcast=%b expected %b", t, got, e);
        end
      end
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1: held in reset with a frame presented
    frameEnd = 1; destAddr = BCAST; frameLen = 100; addrHit = 1;
    repeat (3) @(negedge clk);
    vectors++;
    if ({incGood, incBcast, incMcast} !== 3'b000) begin
      fails++;
      $display("FAIL R1: got %b expected 000", {incGood, incBcast, incMcast});
    end
    frameEnd = 0;
    @(negedge clk);
    rstN = 1;
    monitorOn = 1;
    idle("R1 after reset");
    // basic classes
    present(1, UCAST, 200, 1, 0, 0, 0, 0, 0, "R3 unicast hit");
    present(1, BCAST, 200, 1, 0, 0, 0, 0, 0, "R6 broadcast");
    present(1, MCAST, 200, 1, 0, 0, 0, 0, 0, "R7 multicast");
    present(1, NEARB, 200, 1, 0, 0, 0, 0, 0, "R7 near-all-ones group");
    present(1, 48'h7FFF_FFFF_FFFF, 200, 1, 0, 0, 0, 0, 0, "R6 not all ones");
    idle("R2 idle gap");
    present(1, UCAST, 200, 0, 1, 0, 0, 0, 0, "R3 promiscuous");
    present(1, MCAST, 200, 0, 0, 0, 0, 0, 0, "R3 no accept");
    present(1, BCAST, 200, 0, 0, 0, 0, 0, 0, "R3 no accept bcast");
    // lengths
    present(1, MCAST, 63, 1, 0, 0, 0, 0, 0, "R4 len 63");
    present(1, MCAST, 64, 1, 0, 0, 0, 0, 0, "R4 len 64");
    present(1, BCAST, 1518, 1, 0, 0, 0, 0, 0, "R4 len max");
    present(1, BCAST, 1519, 1, 0, 0, 0, 0, 0, "R4 len max+1");
    @(negedge clk); maxLen = 100; expQ.push_back(3'b000); tagQ.push_back("R2 setup");
    frameEnd = 0;
    present(1, UCAST, 100, 1, 0, 0, 0, 0, 0, "R4 narrow max");
    present(1, UCAST, 101, 1, 0, 0, 0, 0, 0, "R4 narrow max+1");
    @(negedge clk); maxLen = 63; expQ.push_back(3'b000); tagQ.push_back("R2 setup");
    frameEnd = 0;
    present(1, BCAST, 63, 1, 1, 0, 0, 0, 0, "R4 empty window 63");
    present(1, BCAST, 64, 1, 1, 0, 0, 0, 0, "R4 empty window 64");
    @(negedge clk); maxLen = 1518; expQ.push_back(3'b000); tagQ.push_back("R2 setup");
    frameEnd = 0;
    // errors
    present(1, BCAST, 200, 1, 0, 1, 0, 0, 0, "R5 crc");
    present(1, MCAST, 200, 1, 0, 0, 1, 0, 0, "R5 align");
    present(1, UCAST, 200, 1, 0, 0, 0, 1, 0, "R5 code");
    present(1, BCAST, 200, 1, 1, 1, 1, 1, 0, "R5 all errors");
    // overrun pairs
    present(1, BCAST, 300, 1, 0, 0, 0, 0, 1, "R9 overrun bcast");
    present(1, MCAST, 300, 1, 0, 0, 0, 0, 1, "R9 overrun mcast");
    present(1, UCAST, 300, 1, 0, 0, 0, 0, 1, "R9 overrun ucast");
    present(1, UCAST, 30, 1, 0, 0, 0, 0, 1, "R9 overrun short");
    present(0, BCAST, 300, 1, 0, 0, 0, 0, 1, "R9 overrun no end");
    // back-to-back and R8 coexistence
    present(1, BCAST, 64, 0, 1, 0, 0, 0, 0, "R8 bcast with good");
    present(1, MCAST, 64, 0, 1, 0, 0, 0, 0, "R8 mcast with good");
    idle("R2 trailing idle");
    idle("R2 trailing idle");
    @(negedge clk); frameEnd = 0;
    repeat (3) @(posedge clk);
    #6;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule